// File: doc/BRIEF.md
# Control Register Unlock Sequencer

This block holds the 8-bit control register of a serial memory with a supervisor function. It sits behind a serial slave front end that has already decoded the bus traffic. The front end passes in three kinds of event: each data byte written to the register address, each stop condition, and each attempted array write together with its target address. The block also samples the write-protect pin and a busy flag from the storage cells. It answers every register data byte with a one-cycle acknowledge or refusal pulse. It keeps the two volatile enable latches and the nonvolatile fields, which are the watchdog period, the block-protect code and the sticky hardware-protect enable. When a register update must be stored, it raises a one-cycle start pulse for the nonvolatile cycle. It also reports whether the presented array address may be written.

The nonvolatile fields only change after an exact three-write unlock sequence. The first write, 02h, arms the write latch. The second write, 06h, arms the register latch. The third write carries the new field values. Each write is a single data byte and only takes effect at the stop that closes its transaction. Reads go through the `ctrl_o` output and never disturb the sequence.

Top module: `wel_seq`

## Requirements
- R1: While reset is held and after reset, `ctrl_o` is 60h. Bit layout from bit 7 down to bit 0: hardware-protect enable, watchdog bits 1 and 0, protect-code bits 1 and 0, register latch, write latch, protect-code bit 2. After reset, `ack_o`, `nack_o`, `nv_start_o` and `arr_wr_ok_o` are all 0.
- R2: The first data byte of a transaction is answered in the next cycle. It gets `ack_o` if the byte is accepted and `nack_o` if it is not. With the register latch clear, a byte is accepted when the write latch is set or when the byte is 02h.
- R3: With the register latch clear, a committed byte updates the latches. 02h sets the write latch. 06h sets both the write latch and the register latch. 00h clears the write latch. None of these raises `nv_start_o`.
- R4: With the register latch set, an accepted byte with bit 2 = 0 takes effect at the stop. The fields load as follows: bit 7 to the protect enable, bits 6:5 to the watchdog bits, bits 4:3 to protect-code bits 1:0, and bit 0 to protect-code bit 2. The register latch clears, the write latch stays set, and `nv_start_o` pulses for one cycle.
- R5: With the register latch set, a byte with bit 2 = 1 leaves every field unchanged and keeps the register latch set.
- R6: A second data byte in the same transaction is refused, and the stop that follows changes nothing.
- R7: A stop with no data byte before it leaves `ctrl_o` unchanged.
- R8: While `nv_busy` is 1, any data byte is refused and has no effect.
- R9: When `wp_pin` and the protect enable are both 1, a byte that would commit the nonvolatile fields is refused. The fields and the register latch stay as they were.
- R10: `arr_wr_ok_o` is 1 only when the write latch is set and the address is not protected. The protect code {bit2,bit1,bit0} maps to a range as follows, with 64-byte pages on a 14-bit address: 000 protects nothing; 001 the top quarter; 010 the top half; 011 all addresses; 100 page 0; 101 pages 0–1; 110 pages 0–3; 111 pages 0–7.
- R11: An array write attempt (`arr_try`) to a protected address clears the register latch in the next cycle. An attempt to an unprotected address leaves the latch as it was.
- R12: With the register latch clear, an accepted byte other than 02h, 06h or 00h is acknowledged and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_vld | input | 1 | One-cycle pulse: data byte written to the register |
| byte_data | input | 8 | Data byte value |
| stop_evt | input | 1 | One-cycle pulse: stop condition ends the transaction |
| nv_busy | input | 1 | Nonvolatile cycle in progress |
| wp_pin | input | 1 | Hardware write-protect pin |
| arr_try | input | 1 | One-cycle pulse: array write attempt |
| arr_addr | input | ADDR_W | Array address under test |
| ack_o | output | 1 | Byte accepted (one cycle) |
| nack_o | output | 1 | Byte refused (one cycle) |
| nv_start_o | output | 1 | Start nonvolatile store (one cycle) |
| ctrl_o | output | 8 | Current control register value |
| arr_wr_ok_o | output | 1 | Array address may be written |

## Verification
The bench feeds every one of the 256 byte values as the third write of the unlock sequence and predicts the resulting register from the field mapping. A design that swapped the split protect-code bit or mishandled bit 2 would show the wrong register value or a missing or stray start pulse. It sweeps each block-protect code across the address space at both edges of every 32-byte span. A wrong page count or quarter boundary therefore shows as a wrong permission flag. It also targets transactions with two bytes or none, the busy refusal, the hardware-protect lock, and latch loss on a protected array write. A design that counted bytes loosely or ignored the pin would commit a refused byte.

// File: rtl/wel_seq_pkg.sv
package wel_seq_pkg;

  typedef struct packed {
    logic       hw_en;   // bit 7: sticky hardware-protect enable
    logic [1:0] wd;      // bits 6:5: watchdog period
    logic [1:0] bp_lo;   // bits 4:3: protect code bits 1:0
    logic       rwel;    // bit 2: register write latch
    logic       wel;     // bit 1: write latch
    logic       bp_hi;   // bit 0: protect code bit 2
  } ctrl_t;

  localparam logic [7:0] CTRL_RST  = 8'h60;
  localparam logic [7:0] PAT_WEL   = 8'h02;
  localparam logic [7:0] PAT_RWEL  = 8'h06;
  localparam logic [7:0] PAT_CLR   = 8'h00;
  localparam int         HOLD_BIT  = 2;

  typedef enum logic [1:0] {TX_IDLE, TX_ONE, TX_MANY} txn_e;

  function automatic logic byte_accept(input ctrl_t c, input logic [7:0] d,
                                       input logic busy, input logic wp);
    logic ok;
    if (busy) ok = 1'b0;
    else if (c.rwel && !d[HOLD_BIT]) ok = !(wp && c.hw_en);
    else ok = c.wel || (d == PAT_WEL);
    return ok;
  endfunction

endpackage

// File: rtl/wel_seq_txn.sv
module wel_seq_txn
  import wel_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       byte_vld,
  input  logic [7:0] byte_data,
  input  logic       stop_evt,
  input  logic       byte_ok,
  output logic       ack_o,
  output logic       nack_o,
  output logic       commit_o,
  output logic [7:0] commit_data_o
);

  txn_e       st_q, st_d;
  logic       pend_q, pend_d;
  logic [7:0] data_q;
  logic       data_en;
  logic       ack_d, nack_d;

  always_comb begin
    st_d    = st_q;
    pend_d  = pend_q;
    data_en = 1'b0;
    ack_d   = 1'b0;
    nack_d  = 1'b0;
    if (stop_evt) begin
      st_d   = TX_IDLE;
      pend_d = 1'b0;
    end else if (byte_vld) begin
      if (st_q == TX_IDLE) begin
        st_d    = TX_ONE;
        pend_d  = byte_ok;
        data_en = 1'b1;
        ack_d   = byte_ok;
        nack_d  = !byte_ok;
      end else begin
        st_d   = TX_MANY;
        pend_d = 1'b0;
        nack_d = 1'b1;
      end
    end
  end

  assign commit_o      = stop_evt && (st_q == TX_ONE) && pend_q;
  assign commit_data_o = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= TX_IDLE;
      pend_q <= 1'b0;
      ack_o  <= 1'b0;
      nack_o <= 1'b0;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_d;
      ack_o  <= ack_d;
      nack_o <= nack_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= 8'h00;
    else if (data_en) data_q <= byte_data;
  end

endmodule

// File: rtl/wel_seq_regs.sv
module wel_seq_regs
  import wel_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       commit,
  input  logic [7:0] commit_data,
  input  logic       drop_rwel,
  output ctrl_t      ctrl_o,
  output logic       nv_start_o
);

  ctrl_t ctrl_q, ctrl_d;
  logic  start_d;

  always_comb begin
    ctrl_d  = ctrl_q;
    start_d = 1'b0;
    if (commit) begin
      if (ctrl_q.rwel) begin
        if (!commit_data[HOLD_BIT]) begin
          ctrl_d.hw_en = commit_data[7];
          ctrl_d.wd    = commit_data[6:5];
          ctrl_d.bp_lo = commit_data[4:3];
          ctrl_d.bp_hi = commit_data[0];
          ctrl_d.rwel  = 1'b0;
          start_d      = 1'b1;
        end
      end else begin
        case (commit_data)
          PAT_WEL:  ctrl_d.wel = 1'b1;
          PAT_RWEL: begin
            ctrl_d.wel  = 1'b1;
            ctrl_d.rwel = 1'b1;
          end
          PAT_CLR:  ctrl_d.wel = 1'b0;
          default:  ;
        endcase
      end
    end
    if (drop_rwel) ctrl_d.rwel = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= ctrl_t'(CTRL_RST);
      nv_start_o <= 1'b0;
    end else begin
      ctrl_q     <= ctrl_d;
      nv_start_o <= start_d;
    end
  end

  assign ctrl_o = ctrl_q;

endmodule

// File: rtl/wel_seq_prot.sv
module wel_seq_prot #(
  parameter int ADDR_W = 14,
  parameter int PAGE_W = 6
) (
  input  logic [2:0]        code,
  input  logic [ADDR_W-1:0] addr,
  output logic              prot_o
);

  localparam int PIDX_W = ADDR_W - PAGE_W;

  logic [PIDX_W-1:0] page_idx;
  logic [PIDX_W-1:0] page_lim;

  assign page_idx = addr[ADDR_W-1:PAGE_W];
  assign page_lim = PIDX_W'(1) << code[1:0];

  always_comb begin
    case (code)
      3'b000:  prot_o = 1'b0;
      3'b001:  prot_o = &addr[ADDR_W-1 -: 2];
      3'b010:  prot_o = addr[ADDR_W-1];
      3'b011:  prot_o = 1'b1;
      default: prot_o = page_idx < page_lim;
    endcase
  end

endmodule

// File: rtl/wel_seq.sv
module wel_seq
  import wel_seq_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int PAGE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_vld,
  input  logic [7:0]        byte_data,
  input  logic              stop_evt,
  input  logic              nv_busy,
  input  logic              wp_pin,
  input  logic              arr_try,
  input  logic [ADDR_W-1:0] arr_addr,
  output logic              ack_o,
  output logic              nack_o,
  output logic              nv_start_o,
  output logic [7:0]        ctrl_o,
  output logic              arr_wr_ok_o
);

  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  ctrl_t      ctrl;
  logic       byte_ok;
  logic       commit;
  logic [7:0] commit_data;
  logic       prot;

  assign byte_ok = byte_accept(ctrl, byte_data, nv_busy, wp_pin);

  wel_seq_txn u_txn (
    .clk          (clk),
    .rst_n        (rst_n_s),
    .byte_vld     (byte_vld),
    .byte_data    (byte_data),
    .stop_evt     (stop_evt),
    .byte_ok      (byte_ok),
    .ack_o        (ack_o),
    .nack_o       (nack_o),
    .commit_o     (commit),
    .commit_data_o(commit_data)
  );

  wel_seq_prot #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_prot (
    .code  ({ctrl.bp_hi, ctrl.bp_lo}),
    .addr  (arr_addr),
    .prot_o(prot)
  );

  wel_seq_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .commit     (commit),
    .commit_data(commit_data),
    .drop_rwel  (arr_try && prot),
    .ctrl_o     (ctrl),
    .nv_start_o (nv_start_o)
  );

  assign ctrl_o      = ctrl;
  assign arr_wr_ok_o = ctrl.wel && !prot;

endmodule

// File: rtl/wel_seq_chk.sv
module wel_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       byte_vld,
  input logic       stop_evt,
  input logic       nv_busy,
  input logic       arr_try,
  input logic       ack_o,
  input logic       nack_o,
  input logic       nv_start_o,
  input logic [7:0] ctrl_o,
  input logic       arr_wr_ok_o
);

  a_r2_ack_nack_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack_o && nack_o));

  a_r2_reply_needs_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o || nack_o) |-> $past(byte_vld));

  a_r8_busy_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && nv_busy) |=> !ack_o);

  a_r3_rwel_implies_wel: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_o[2] |-> ctrl_o[1]);

  a_r4_start_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    nv_start_o |-> $past(stop_evt));

  a_r4_start_clears_rwel: assert property (@(posedge clk) disable iff (!rst_n)
    nv_start_o |-> !ctrl_o[2]);

  a_r5_nv_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !nv_start_o |-> $stable({ctrl_o[7:3], ctrl_o[0]}));

  a_r10_ok_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
    arr_wr_ok_o |-> ctrl_o[1]);

  a_r11_prot_try_drops_rwel: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_try && !arr_wr_ok_o) |=> !ctrl_o[2]);

endmodule

bind wel_seq wel_seq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .byte_vld   (byte_vld),
  .stop_evt   (stop_evt),
  .nv_busy    (nv_busy),
  .arr_try    (arr_try),
  .ack_o      (ack_o),
  .nack_o     (nack_o),
  .nv_start_o (nv_start_o),
  .ctrl_o     (ctrl_o),
  .arr_wr_ok_o(arr_wr_ok_o)
);

// File: tb/sim_wel_seq.sv
module sim_wel_seq;
  localparam int AW = 14;
  localparam int PW = 6;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n, byte_vld, stop_evt, nv_busy, wp_pin, arr_try;
  logic [7:0]    byte_data;
  logic [AW-1:0] arr_addr;
  logic          ack_o, nack_o, nv_start_o, arr_wr_ok_o;
  logic [7:0]    ctrl_o;

  wel_seq #(.ADDR_W(AW), .PAGE_W(PW)) u0 (.*);

  int n_run = 0;
  int n_fail = 0;
  bit m_wel, m_rwel, m_hw;
  bit [1:0] m_wd;
  bit [2:0] m_bp;

  function automatic bit [7:0] mctrl();
    return {m_hw, m_wd, m_bp[1:0], m_rwel, m_wel, m_bp[2]};
  endfunction

  function automatic bit mprot(bit [2:0] c, int a);
    case (c)
      3'd0: return 1'b0;
      3'd1: return a >= 3 * (1 << (AW - 2));
      3'd2: return a >= (1 << (AW - 1));
      3'd3: return 1'b1;
      default: return a < ((1 << c[1:0]) << PW);
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic apply_model(input bit [7:0] d);
    if (m_rwel) begin
      if (!d[2]) begin
        m_hw = d[7]; m_wd = d[6:5]; m_bp = {d[0], d[4:3]}; m_rwel = 0;
      end
    end else begin
      case (d)
        8'h02: m_wel = 1;
        8'h06: begin m_wel = 1; m_rwel = 1; end
        8'h00: m_wel = 0;
        default: ;
      endcase
    end
  endtask

  // one-byte register write with stop; expectations from the requirement model
  task automatic wr1(input bit [7:0] d, input string tag);
    bit acc, nv;
    if (nv_busy) acc = 0;
    else if (m_rwel && !d[2]) acc = !(wp_pin && m_hw);
    else acc = m_wel || d == 8'h02;
    nv = acc && m_rwel && !d[2];
    @(negedge clk); byte_vld = 1; byte_data = d;
    @(negedge clk); byte_vld = 0;
    chk(ack_o == acc && nack_o == !acc, {tag, " reply"}, {ack_o, nack_o}, {acc, !acc});
    stop_evt = 1;
    @(negedge clk); stop_evt = 0;
    if (acc) apply_model(d);
    chk(nv_start_o == nv, {tag, " nv_start"}, nv_start_o, nv);
    chk(ctrl_o == mctrl(), {tag, " ctrl"}, ctrl_o, mctrl());
  endtask

  task automatic try_arr(input int a, input string tag);
    @(negedge clk); arr_try = 1; arr_addr = AW'(a);
    @(negedge clk); arr_try = 0;
    if (mprot(m_bp, a)) m_rwel = 0;
    chk(ctrl_o == mctrl(), tag, ctrl_o, mctrl());
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; byte_vld = 0; stop_evt = 0; nv_busy = 0; wp_pin = 0;
    arr_try = 0; byte_data = 0; arr_addr = 0;
    m_wel = 0; m_rwel = 0; m_hw = 0; m_wd = 2'b11; m_bp = 0;
    repeat (3) @(negedge clk);
    chk(ctrl_o == 8'h60, "R1 ctrl in reset", ctrl_o, 8'h60);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(ctrl_o == 8'h60 && !ack_o && !nack_o && !nv_start_o && !arr_wr_ok_o,
        "R1 after reset", {ctrl_o, ack_o, nack_o, nv_start_o, arr_wr_ok_o}, 12'h600);

    // R7: stop without data
    @(negedge clk); stop_evt = 1;
    @(negedge clk); stop_evt = 0;
    chk(ctrl_o == mctrl() && !nv_start_o, "R7 bare stop", ctrl_o, mctrl());

    // R2: 06h with write latch clear is refused; R3 latch patterns
    wr1(8'h06, "R2 06 without wel");
    wr1(8'h02, "R3 set wel");
    wr1(8'h00, "R3 clear wel");
    wr1(8'h55, "R2 other byte without wel");
    wr1(8'h02, "R3 set wel again");
    wr1(8'h55, "R12 other byte ignored");
    wr1(8'h06, "R3 set rwel");
    wr1(8'h06, "R5 hold with bit2");
    wr1(8'h02, "R4 commit zeros");

    // R8: busy
    nv_busy = 1;
    wr1(8'h00, "R8 busy refused");
    nv_busy = 0;

    // R6: two bytes in one transaction
    wr1(8'h06, "R6 arm");
    @(negedge clk); byte_vld = 1; byte_data = 8'h00;
    @(negedge clk); byte_vld = 1; byte_data = 8'h18;
    @(negedge clk); byte_vld = 0;
    chk(nack_o && !ack_o, "R6 second byte refused", {ack_o, nack_o}, 2'b01);
    stop_evt = 1;
    @(negedge clk); stop_evt = 0;
    chk(ctrl_o == mctrl() && !nv_start_o, "R6 no commit", ctrl_o, mctrl());

    // R4/R5: every third-write value after the unlock
    for (int d = 0; d < 256; d++) begin
      wr1(8'h02, "R4 unlock a");
      wr1(8'h06, "R4 unlock b");
      wr1(8'(d), "R4 R5 third write");
    end

    // R9: hardware lock
    wr1(8'h02, "R9 a"); wr1(8'h06, "R9 b"); wr1(8'h80, "R9 set hw enable");
    wp_pin = 1;
    wr1(8'h02, "R9 c"); wr1(8'h06, "R9 d");
    wr1(8'h38, "R9 locked commit refused");
    wr1(8'h06, "R9 hold allowed");
    wp_pin = 0;
    wr1(8'h00, "R9 unlocked commit");

    // R10: permission sweep over every protect code
    for (int c = 0; c < 8; c++) begin
      bit [7:0] d;
      d = {1'b0, 2'b11, c[1:0], 2'b01, c[2]};
      wr1(8'h02, "R10 a"); wr1(8'h06, "R10 b"); wr1(d, "R10 set code");
      for (int a = 0; a < (1 << AW); a += 32) begin
        for (int k = 0; k < 2; k++) begin
          int ad;
          bit e;
          ad = a + k * 31;
          arr_addr = AW'(ad);
          #1;
          e = m_wel && !mprot(m_bp, ad);
          chk(arr_wr_ok_o == e, "R10 permission", arr_wr_ok_o, e);
        end
      end
    end
    wr1(8'h00, "R10 drop wel");
    arr_addr = 0; #1;
    chk(!arr_wr_ok_o, "R10 no wel", arr_wr_ok_o, 0);

    // R11: protected array write drops register latch (code 111 now: pages 0-7 set below)
    wr1(8'h02, "R11 a"); wr1(8'h06, "R11 b"); wr1(8'h19, "R11 code 111");
    wr1(8'h06, "R11 arm");
    try_arr(1000, "R11 unprotected keeps rwel");
    try_arr(100, "R11 protected drops rwel");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule